// File: doc/BRIEF.md
# Zero-Skipping Sparse Convolution Lanes

This block runs the sparse part of a mixed-precision convolution: the small group of large-magnitude activations that are kept as 8-bit floating-point values. Activations arrive as a stream of (position, value) pairs in ascending position order. Zero values are dropped before any arithmetic is spent on them. For every non-zero entry the block fetches that position's three-tap weight word from an external weight memory. It hands the entry to one of four parallel 3x1 multiply lanes. The three resulting products are scattered into the output positions p-1, p and p+1.

A scoreboard marks output positions that have an accumulation in flight. It holds back any entry that would touch one of them. The partial sums live in a circular reorder window. The window is drained strictly in position order. Every position of the frame is emitted exactly once, including positions that received nothing. An optional leaky activation is applied on the way out.

Top module: `sparse_conv_lanes`

## Requirements
- R1: An 8-bit value has sign bit 7, exponent bits [6:3] and mantissa bits [2:0]. Its significand is {1,m} with shift e-1 when e is non-zero, and {0,m} with shift 0 when e is zero. Each product is (sigA*sigB) shifted left by shiftA+shiftB and then right by ACC_SHR (default 8). The result is truncated to 24 bits, negated when the two signs differ, and summed into the output modulo 2^24.
- R2: For an entry at position p, weight word bits [7:0] feed position p-1, bits [15:8] feed position p and bits [23:16] feed position p+1. Targets below 0 or above NPOS-1 are dropped.
- R3: An entry whose bits [6:0] are all zero (either signed zero) is never issued to a lane and has no effect on any output.
- R4: Every position 0..NPOS-1 of a frame appears on the output exactly once, in ascending order, at most one per cycle. A position with no contributions is emitted as zero.
- R5: wAddr presents the index of the entry being accepted. wData is taken one cycle later. While an accepted entry waits to issue, wAddr keeps its index.
- R6: An entry is not issued while any of its target positions has an accumulation in flight. No position is emitted while it can still receive a contribution.
- R7: An entry at position p is accepted only when p+1 lies inside the WIN_DEPTH-entry window (default 16) that starts at the oldest position not yet emitted. Otherwise the input stalls.
- R8: When actEn is 1, a negative result is arithmetically shifted right by LEAK_SHIFT (default 3) on output. When actEn is 0, results pass unchanged.
- R9: An entry with inLast ends the frame. inReady stays low from then until all NPOS positions have been emitted.
- R10: After reset outValid is 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| actEn | input | 1 | Leaky activation on outputs |
| inValid | input | 1 | Input entry valid |
| inReady | output | 1 | Input entry accepted when high with inValid |
| inValue | input | 8 | 8-bit floating-point activation |
| inIndex | input | IDX_W | Position of the entry, ascending within a frame |
| inLast | input | 1 | Final entry of the frame |
| wAddr | output | IDX_W | Weight memory read address |
| wData | input | 24 | Three weight taps, one cycle after the address |
| outValid | output | 1 | Output valid |
| outIndex | output | IDX_W | Output position |
| outData | output | 24 | Accumulated, activated result |

## Verification
The bench builds the block with its defaults: 64 positions, a 16-entry window, four lanes and a lane latency of 4. Because a frame has four times as many positions as the window, an entry that jumps far ahead must stall until the window drains. Dense runs of neighbouring non-zeros overlap their targets, so with a four-cycle lane latency the scoreboard waits and the held weight address come into play. Edge positions 0 and 63, all-zero frames and signed zeros are driven directly. Random frames of varying density cover the rest.

// File: rtl/sparse_conv_pkg.sv
package sparse_conv_pkg;

  localparam int ACC_W = 24;

  typedef struct packed {
    logic       accept;
    logic       dispatch;
    logic       wbEn;
    logic [2:0] wbMask;
    logic       emit;
    logic       frameClear;
  } sconv_strobe_t;

  // aligned fixed-point product of two 8-bit floating-point operands
  function automatic logic [ACC_W-1:0] alignProd(input logic [7:0] a, input logic [7:0] b,
                                                  input int shr);
    logic [3:0]       sigA, sigB;
    logic [5:0]       shA, shB;
    logic [63:0]      wide;
    logic [ACC_W-1:0] mag;
    sigA = (a[6:3] == 4'd0) ? {1'b0, a[2:0]} : {1'b1, a[2:0]};
    sigB = (b[6:3] == 4'd0) ? {1'b0, b[2:0]} : {1'b1, b[2:0]};
    shA  = (a[6:3] == 4'd0) ? 6'd0 : (6'(a[6:3]) - 6'd1);
    shB  = (b[6:3] == 4'd0) ? 6'd0 : (6'(b[6:3]) - 6'd1);
    wide = 64'(8'(sigA * sigB)) << (shA + shB);
    wide = wide >> shr;
    mag  = wide[ACC_W-1:0];
    return (a[7] ^ b[7]) ? (~mag + 1'b1) : mag;
  endfunction

endpackage

// File: rtl/sconv_lane_mul.sv
module sconv_lane_mul
  import sparse_conv_pkg::*;
#(
  parameter int ACC_SHR = 8
) (
  input  logic [7:0]            xVal,
  input  logic [23:0]           wWord,
  output logic [2:0][ACC_W-1:0] prod
);
  for (genvar k = 0; k < 3; k++) begin : g_tap
    assign prod[k] = alignProd(xVal, wWord[8*k +: 8], ACC_SHR);
  end
endmodule

// File: rtl/sconv_ctrl.sv
module sconv_ctrl
  import sparse_conv_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int WIN_DEPTH = 16,
  parameter int LANES     = 4,
  parameter int LANE_LAT  = 4,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inValue,
  input  logic [IDX_W-1:0]  inIndex,
  input  logic              inLast,
  output logic              inReady,
  output logic [IDX_W-1:0]  wAddr,
  output sconv_strobe_t     strb,
  output logic [LANE_W-1:0] dispatchLane,
  output logic [IDX_W-1:0]  dispatchPos,
  output logic [LANE_W-1:0] wbLane,
  output logic [IDX_W-1:0]  wbPos,
  output logic [IDX_W-1:0]  emitPos
);
  localparam int NPOS  = 1 << IDX_W;
  localparam int WIN_W = $clog2(WIN_DEPTH);
  localparam int CNT_W = $clog2(LANE_LAT + 1);
  localparam int PW    = IDX_W + 2;

  logic                 s1Valid, s1Nz, seenAny, frameDone;
  logic [IDX_W-1:0]     s1Idx, seenIdx;
  logic [IDX_W:0]       head;
  logic [WIN_DEPTH-1:0] pending, pendNext;
  logic [LANES-1:0]     laneBusy;
  logic [CNT_W-1:0]     laneCnt  [LANES];
  logic [IDX_W-1:0]     lanePos  [LANES];
  logic [2:0]           laneMask [LANES];

  logic             inNz, roomOk, conflict, laneAvail, s1Go, accept, wbHit;
  logic             haveFront, headFin, emit, frameClear;
  logic [2:0]       tMask, wbMaskSel;
  logic [PW-1:0]    tPos [3];
  logic [PW-1:0]    wPos [3];
  logic [PW-1:0]    front;
  logic [LANE_W-1:0] freeLane, wbSel;

  assign inNz   = |inValue[6:0];
  assign roomOk = (PW'(inIndex) + PW'(1)) < (PW'(head) + PW'(WIN_DEPTH));

  // targets of the waiting entry
  assign tMask = {s1Idx != IDX_W'(NPOS - 1), 1'b1, s1Idx != '0};
  always_comb begin
    conflict = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tPos[k] = PW'(s1Idx) + PW'(k) - PW'(1);
      if (tMask[k] && pending[tPos[k][WIN_W-1:0]]) conflict = 1'b1;
    end
  end

  always_comb begin
    laneAvail = 1'b0;
    freeLane  = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (!laneBusy[i]) begin
        laneAvail = 1'b1;
        freeLane  = LANE_W'(i);
      end
    end
  end

  always_comb begin
    wbHit = 1'b0;
    wbSel = '0;
    for (int i = 0; i < LANES; i++) begin
      if (laneBusy[i] && laneCnt[i] == CNT_W'(1)) begin
        wbHit = 1'b1;
        wbSel = LANE_W'(i);
      end
    end
  end

  assign s1Go    = s1Valid && (!s1Nz || (laneAvail && !conflict));
  assign inReady = !frameDone && (!s1Valid || s1Go) && roomOk;
  assign accept  = inValid && inReady;
  assign wAddr   = (s1Valid && !s1Go) ? s1Idx : inIndex;

  assign wbMaskSel = laneMask[wbSel];
  always_comb begin
    for (int k = 0; k < 3; k++) wPos[k] = PW'(lanePos[wbSel]) + PW'(k) - PW'(1);
  end

  // highest position the stream has proven it will not go back below
  always_comb begin
    haveFront = 1'b1;
    front     = '0;
    if (s1Valid)        front = PW'(s1Idx);
    else if (frameDone) front = PW'(NPOS + 1);
    else if (inValid)   front = PW'(inIndex);
    else if (seenAny)   front = PW'(seenIdx);
    else                haveFront = 1'b0;
  end

  assign headFin    = haveFront && (front > PW'(head) + PW'(1)) && !pending[head[WIN_W-1:0]];
  assign emit       = headFin && !head[IDX_W];
  assign frameClear = frameDone && head[IDX_W] && !s1Valid;

  always_comb begin
    pendNext = pending;
    if (wbHit)
      for (int k = 0; k < 3; k++) if (wbMaskSel[k]) pendNext[wPos[k][WIN_W-1:0]] = 1'b0;
    if (s1Go && s1Nz)
      for (int k = 0; k < 3; k++) if (tMask[k]) pendNext[tPos[k][WIN_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s1Nz      <= 1'b0;
      s1Idx     <= '0;
      seenAny   <= 1'b0;
      seenIdx   <= '0;
      frameDone <= 1'b0;
      head      <= '0;
      pending   <= '0;
    end else begin
      pending <= pendNext;
      if (accept) begin
        s1Valid <= 1'b1;
        s1Idx   <= inIndex;
        s1Nz    <= inNz;
        seenAny <= 1'b1;
        seenIdx <= inIndex;
        if (inLast) frameDone <= 1'b1;
      end else if (s1Go) begin
        s1Valid <= 1'b0;
      end
      if (frameClear) begin
        head      <= '0;
        frameDone <= 1'b0;
        seenAny   <= 1'b0;
      end else if (emit) begin
        head <= head + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneBusy[g] <= 1'b0;
        laneCnt[g]  <= '0;
        lanePos[g]  <= '0;
        laneMask[g] <= '0;
      end else if (s1Go && s1Nz && freeLane == LANE_W'(g)) begin
        laneBusy[g] <= 1'b1;
        laneCnt[g]  <= CNT_W'(LANE_LAT);
        lanePos[g]  <= s1Idx;
        laneMask[g] <= tMask;
      end else if (laneBusy[g]) begin
        laneCnt[g] <= laneCnt[g] - 1'b1;
        if (laneCnt[g] == CNT_W'(1)) laneBusy[g] <= 1'b0;
      end
    end
  end

  assign strb.accept     = accept;
  assign strb.dispatch   = s1Go && s1Nz;
  assign strb.wbEn       = wbHit;
  assign strb.wbMask     = wbMaskSel;
  assign strb.emit       = emit;
  assign strb.frameClear = frameClear;
  assign dispatchLane    = freeLane;
  assign dispatchPos     = s1Idx;
  assign wbLane          = wbSel;
  assign wbPos           = lanePos[wbSel];
  assign emitPos         = head[IDX_W-1:0];
endmodule

// File: rtl/sconv_dpath.sv
module sconv_dpath
  import sparse_conv_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int WIN_DEPTH  = 16,
  parameter int LANES      = 4,
  parameter int ACC_SHR    = 8,
  parameter int LEAK_SHIFT = 3,
  localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              actEn,
  input  logic [7:0]        inValue,
  input  logic [23:0]       wData,
  input  sconv_strobe_t     strb,
  input  logic [LANE_W-1:0] dispatchLane,
  input  logic [LANE_W-1:0] wbLane,
  input  logic [IDX_W-1:0]  wbPos,
  input  logic [IDX_W-1:0]  emitPos,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIndex,
  output logic [ACC_W-1:0]  outData
);
  localparam int WIN_W = $clog2(WIN_DEPTH);
  localparam int PW    = IDX_W + 2;

  logic [7:0]             s1Val;
  logic [2:0][ACC_W-1:0]  mulProd, wbProd;
  logic [2:0][ACC_W-1:0]  laneProd [LANES];
  logic [ACC_W-1:0]       acc [WIN_DEPTH];
  logic [WIN_W-1:0]       wbSlot [3];
  logic [WIN_W-1:0]       emitSlot;
  logic [ACC_W-1:0]       headVal, actVal;
  logic [PW-1:0]          tPos [3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            s1Val <= '0;
    else if (strb.accept) s1Val <= inValue;
  end

  sconv_lane_mul #(.ACC_SHR(ACC_SHR)) u_mul (
    .xVal (s1Val),
    .wWord(wData),
    .prod (mulProd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneProd[g] <= '0;
      else if (strb.dispatch && dispatchLane == LANE_W'(g)) laneProd[g] <= mulProd;
    end
  end

  assign wbProd   = laneProd[wbLane];
  assign emitSlot = emitPos[WIN_W-1:0];
  always_comb begin
    for (int k = 0; k < 3; k++) begin
      tPos[k]   = PW'(wbPos) + PW'(k) - PW'(1);
      wbSlot[k] = tPos[k][WIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WIN_DEPTH; i++) acc[i] <= '0;
    end else begin
      if (strb.emit) acc[emitSlot] <= '0;
      if (strb.wbEn)
        for (int k = 0; k < 3; k++)
          if (strb.wbMask[k]) acc[wbSlot[k]] <= acc[wbSlot[k]] + wbProd[k];
    end
  end

  assign headVal = acc[emitSlot];
  assign actVal  = (actEn && headVal[ACC_W-1]) ? ACC_W'($signed(headVal) >>> LEAK_SHIFT) : headVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outIndex <= '0;
      outData  <= '0;
    end else begin
      outValid <= strb.emit;
      if (strb.emit) begin
        outIndex <= emitPos;
        outData  <= actVal;
      end
    end
  end
endmodule

// File: rtl/sparse_conv_lanes.sv
module sparse_conv_lanes
  import sparse_conv_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int WIN_DEPTH  = 16,
  parameter int LANES      = 4,
  parameter int LANE_LAT   = 4,
  parameter int ACC_SHR    = 8,
  parameter int LEAK_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             actEn,
  input  logic             inValid,
  output logic             inReady,
  input  logic [7:0]       inValue,
  input  logic [IDX_W-1:0] inIndex,
  input  logic             inLast,
  output logic [IDX_W-1:0] wAddr,
  input  logic [23:0]      wData,
  output logic             outValid,
  output logic [IDX_W-1:0] outIndex,
  output logic [23:0]      outData
);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  sconv_strobe_t     strb;
  logic [LANE_W-1:0] dispatchLane, wbLane;
  logic [IDX_W-1:0]  dispatchPos, wbPos, emitPos;

  sconv_ctrl #(
    .IDX_W(IDX_W), .WIN_DEPTH(WIN_DEPTH), .LANES(LANES), .LANE_LAT(LANE_LAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inValue(inValue), .inIndex(inIndex),
    .inLast(inLast), .inReady(inReady), .wAddr(wAddr), .strb(strb),
    .dispatchLane(dispatchLane), .dispatchPos(dispatchPos), .wbLane(wbLane),
    .wbPos(wbPos), .emitPos(emitPos)
  );

  sconv_dpath #(
    .IDX_W(IDX_W), .WIN_DEPTH(WIN_DEPTH), .LANES(LANES),
    .ACC_SHR(ACC_SHR), .LEAK_SHIFT(LEAK_SHIFT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .actEn(actEn), .inValue(inValue), .wData(wData),
    .strb(strb), .dispatchLane(dispatchLane), .wbLane(wbLane), .wbPos(wbPos),
    .emitPos(emitPos), .outValid(outValid), .outIndex(outIndex), .outData(outData)
  );
endmodule

// File: rtl/sparse_conv_lanes_chk.sv
module sparse_conv_lanes_chk
  import sparse_conv_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int WIN_DEPTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [7:0]       inValue,
  input logic [IDX_W-1:0] inIndex,
  input logic             inLast,
  input logic             outValid,
  input logic [IDX_W-1:0] outIndex,
  input sconv_strobe_t    strb,
  input logic [IDX_W-1:0] dispatchPos,
  input logic [IDX_W-1:0] wbPos,
  input logic [IDX_W-1:0] emitPos
);
  localparam int PW = IDX_W + 2;

  logic [IDX_W-1:0] expIdx;
  logic [IDX_W:0]   emitCnt;
  logic [7:0]       nzCnt;
  logic             lastSeen;
  logic             inFire;

  assign inFire = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expIdx   <= '0;
      emitCnt  <= '0;
      nzCnt    <= '0;
      lastSeen <= 1'b0;
    end else begin
      if (outValid) expIdx <= expIdx + 1'b1;
      if (strb.frameClear) emitCnt <= '0;
      else if (strb.emit)  emitCnt <= emitCnt + 1'b1;
      nzCnt <= nzCnt + 8'(inFire && (|inValue[6:0])) - 8'(strb.dispatch);
      if (strb.frameClear)        lastSeen <= 1'b0;
      else if (inFire && inLast)  lastSeen <= 1'b1;
    end
  end

  a_r4_in_order: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outIndex == expIdx);

  a_r7_window: assert property (@(posedge clk) disable iff (!rstN)
    inFire |-> (PW'(inIndex) + PW'(1)) < (PW'(emitCnt) + PW'(WIN_DEPTH)));

  a_r3_zero_skip: assert property (@(posedge clk) disable iff (!rstN)
    strb.dispatch |-> nzCnt != 8'd0);

  a_r6_emit_behind_wb: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wbEn && strb.emit) |-> (PW'(emitPos) + PW'(1)) < PW'(wbPos));

  a_r6_emit_behind_issue: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dispatch && strb.emit) |-> (PW'(emitPos) + PW'(1)) < PW'(dispatchPos));

  a_r9_hold_after_last: assert property (@(posedge clk) disable iff (!rstN)
    lastSeen |-> !inReady);
endmodule

bind sparse_conv_lanes sparse_conv_lanes_chk #(.IDX_W(IDX_W), .WIN_DEPTH(WIN_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inValue(inValue),
  .inIndex(inIndex), .inLast(inLast), .outValid(outValid), .outIndex(outIndex),
  .strb(strb), .dispatchPos(dispatchPos), .wbPos(wbPos), .emitPos(emitPos)
);

// File: tb/sparse_conv_lanes_bench.sv
module sparse_conv_lanes_bench;
  localparam int NPOS = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        actEn = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inValue = '0;
  logic [5:0]  inIndex = '0;
  logic        inLast = 1'b0;
  logic [5:0]  wAddr;
  logic [23:0] wData = '0;
  logic        outValid;
  logic [5:0]  outIndex;
  logic [23:0] outData;

  int checks = 0;
  int errors = 0;
  int outPtr = 0;
  int cycles = 0;
  string curTag = "R10";

  logic [23:0] wmem [NPOS];
  logic [23:0] expv [NPOS];
  logic [7:0]  eVal [NPOS];
  logic [5:0]  eIdx [NPOS];
  int          nEnt;

  always #2 clk = ~clk;

  sparse_conv_lanes u_sparse_conv_lanes (
    .clk(clk), .rstN(rstN), .actEn(actEn), .inValid(inValid), .inReady(inReady),
    .inValue(inValue), .inIndex(inIndex), .inLast(inLast), .wAddr(wAddr), .wData(wData),
    .outValid(outValid), .outIndex(outIndex), .outData(outData)
  );

  always @(posedge clk) wData <= wmem[wAddr];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] refProd(input logic [7:0] a, input logic [7:0] b);
    longint sa, sb, ea, eb, mag;
    logic [23:0] m;
    ea  = longint'(a[6:3]);
    eb  = longint'(b[6:3]);
    sa  = (ea == 0) ? longint'(a[2:0]) : 8 + longint'(a[2:0]);
    sb  = (eb == 0) ? longint'(b[2:0]) : 8 + longint'(b[2:0]);
    mag = (sa * sb) << (((ea == 0) ? 0 : ea - 1) + ((eb == 0) ? 0 : eb - 1));
    mag = mag >> 8;
    m   = mag[23:0];
    return (a[7] != b[7]) ? 24'(-m) : m;
  endfunction

  task automatic buildExpected();
    for (int j = 0; j < NPOS; j++) expv[j] = '0;
    for (int e = 0; e < nEnt; e++) begin
      if (eVal[e][6:0] != 7'd0) begin
        for (int k = 0; k < 3; k++) begin
          int t = int'(eIdx[e]) - 1 + k;
          if (t >= 0 && t < NPOS) expv[t] = expv[t] + refProd(eVal[e], wmem[eIdx[e]][8*k +: 8]);
        end
      end
    end
    if (actEn)
      for (int j = 0; j < NPOS; j++)
        if (expv[j][23]) expv[j] = 24'($signed(expv[j]) >>> 3);
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (outPtr >= NPOS) begin
        check({"R4 extra output ", curTag}, 32'(outIndex), 32'hFFFF);
      end else begin
        check({"R4 order ", curTag}, 32'(outIndex), 32'(outPtr));
        check({"R1 R2 value ", curTag}, 32'(outData), 32'(expv[outPtr]));
      end
      outPtr++;
    end
  end

  task automatic sendEntry(input logic [5:0] idx, input logic [7:0] val, input logic last);
    inValid = 1'b1;
    inIndex = idx;
    inValue = val;
    inLast  = last;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
  endtask

  task automatic runFrame(input string tag);
    curTag = tag;
    buildExpected();
    outPtr = 0;
    for (int e = 0; e < nEnt; e++) sendEntry(eIdx[e], eVal[e], e == nEnt - 1);
    #1;
    if (outPtr < NPOS) check({"R9 ready low after last ", tag}, 32'(inReady), 32'd0);
    while (outPtr < NPOS) @(negedge clk);
    repeat (3) @(negedge clk);
    check({"R4 count ", tag}, 32'(outPtr), 32'(NPOS));
  endtask

  function automatic logic [7:0] randVal();
    logic [3:0] e = 4'($urandom_range(0, 10));
    return {1'($urandom), e, 3'($urandom)};
  endfunction

  task automatic randWeights();
    for (int i = 0; i < NPOS; i++) wmem[i] = 24'($urandom);
  endtask

  task automatic addEnt(input int idx, input logic [7:0] val);
    eIdx[nEnt] = 6'(idx);
    eVal[nEnt] = val;
    nEnt++;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    randWeights();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 outValid after reset", 32'(outValid), 32'd0);
    check("R10 inReady after reset", 32'(inReady), 32'd1);

    // all-zero frame: only a terminating zero entry
    nEnt = 0;
    addEnt(63, 8'h00);
    runFrame("R4 empty frame");

    // signed zeros everywhere: skipped, outputs stay zero
    nEnt = 0;
    for (int i = 0; i < 64; i += 3) addEnt(i, (i % 2 == 1) ? 8'h80 : 8'h00);
    addEnt(63, 8'h80);
    runFrame("R3 zeros skipped");

    // dense cluster at both edges: scoreboard waits and held weight address
    nEnt = 0;
    for (int i = 0; i < 6; i++) addEnt(i, randVal() | 8'h08);
    for (int i = 58; i < 64; i++) addEnt(i, randVal() | 8'h08);
    runFrame("R6 R5 R2 dense edges");

    // far jumps beyond the window
    nEnt = 0;
    addEnt(2, 8'h4B);
    addEnt(50, 8'hC9);
    addEnt(51, 8'h00);
    addEnt(63, 8'h3A);
    runFrame("R7 window jump");

    // negative results with leaky activation
    actEn = 1'b1;
    nEnt = 0;
    for (int i = 1; i < 64; i += 4) addEnt(i, randVal() | 8'h80);
    addEnt(63, 8'hB4);
    runFrame("R8 leaky");
    actEn = 1'b0;

    // random frames of varying density
    for (int f = 0; f < 10; f++) begin
      int dens = 10 + 9 * f;
      randWeights();
      actEn = 1'($urandom);
      nEnt = 0;
      for (int i = 0; i < 63; i++)
        if (int'($urandom_range(0, 99)) < dens) addEnt(i, ($urandom_range(0, 5) == 0) ? 8'h00 : randVal());
      addEnt(63, randVal());
      runFrame(actEn ? "R1 R8 random" : "R1 R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule